// File: doc/BRIEF.md
# Lockable OTP-Backed Register Bank

This block is the register file of a small security device. It holds three banks behind one byte-wide bank/address/data port. Bank 0 models a one-time-programmable array as registers. It holds a configuration word, a trim byte and twelve secret bytes. Bank 1 holds the master control and status registers. Bank 2 holds the secret-set selector and a 32-bit challenge that is handed to a hash engine outside this block. Every register bit has one access type: read-only, write-only, read/write, clear-on-read, or clear-on-write.

A two-state controller decides when the configuration word takes effect. In `ST_BOOT` it copies the configuration word into the working registers: the chip-select policy, the bus-rate code, the master control defaults and the effective secret locks. It then takes the transition `boot_done` to `ST_READY`, where the port accepts accesses. The transition `soft_reset` leads from `ST_READY` back to `ST_BOOT`; it is taken when bit 0 of master control is written as 1. `ST_BOOT` is also entered while `rst_n` is low. Lock bits written into the configuration word therefore act only after the next reset cycle. From then on they block every later write to the OTP model. Contents of the OTP model survive `rst_n` and soft reset. Only `por_n` restores the factory values.

Top module: `secreg_bank`

## Requirements
- R1: While `rst_n` is low, `ready` and `rd_valid` are 0. After release, the first clock edge runs `ST_BOOT` and `ready` is 1 from then on.
- R2: Master control (bank 1, address 0) holds the OTP write enable in bit 7, interrupt enable in bit 6 and auto-sleep in bit 1; its other bits read 0. On boot, bit 7 clears, bit 6 loads from configuration bit 3 and bit 1 loads from configuration bit 2.
- R3: `cs_hit` follows the effective policy, taken from configuration bits [7:6]: 00 hits only when `frame_cs`=0, 01 and 10 always hit, and 11 hits only when `frame_cs`=1.
- R4: With effective lock bit 1 set, bank 0 addresses 0x2 to 0x9 read 0 and writes to them are dropped. With effective lock bit 0 set, the same holds for addresses 0xA to 0xD.
- R5: Effective locks are copied from configuration bits [1:0] only during boot. While either lock is in effect, every write to bank 0 is dropped. A bank 0 write also needs master control bit 7 set.
- R6: A write to the trim byte (bank 0, address 0x1) is applied only while `test_mode` is 1.
- R7: `rd_valid` is 1 exactly one cycle after an accepted read, with `rd_data` holding the value read. It is 0 otherwise.
- R8: Status (bank 1, address 1) is read-only and laid out as {policy[1:0], rate[1:0], denied, frozen, lock[1:0]}. Bit 3 (denied) is set by a blocked bank 0 access and cleared by a read of status.
- R9: Master control bit 0 is clear-on-write. Writing it as 1 starts a soft reset, so `ready` is 0 in the next cycle. It always reads as 0.
- R10: Bank 2 addresses 0x1 to 0x4 are write-only challenge bytes that read 0. They drive `chal_word`, with address 0x1 in the low byte. Address 0x0 is a 2-bit read/write selector. Boot clears both.
- R11: Unimplemented addresses and banks read 0 and ignore writes. This covers bank 0 above 0xD, bank 1 above 0x1, bank 2 above 0x4 and all of bank 3.
- R12: `rate_sel` shows configuration bits [5:4] as copied at boot. The OTP model keeps its contents through `rst_n` and soft reset, and `por_n` restores the factory values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; reloads factory OTP values |
| rst_n | input | 1 | Device reset, active low; forces boot |
| test_mode | input | 1 | Enables trim writes |
| acc_valid | input | 1 | Access request, accepted when `ready` is 1 |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_bank | input | 2 | Bank select |
| acc_addr | input | 4 | Address within the bank |
| acc_wdata | input | 8 | Write data |
| ready | output | 1 | Controller is in `ST_READY` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| frame_cs | input | 1 | Chip-select bit of an incoming instruction frame |
| cs_hit | output | 1 | Frame is addressed to this device |
| rate_sel | output | 2 | Bus-rate code (00 half, 01 base 5.78 kbps, 10 double, 11 quadruple) |
| chal_word | output | 32 | Challenge value for the hash engine |

## Verification
The bench writes lock bits and checks that secrets stay readable until a soft reset. A design that used the raw OTP bits would blank them at once. After the reboot it checks that the lock hides only its own range and that the trim, configuration and unlocked secret bytes are all frozen. A design that checked the lock per address would let those writes through. It also checks that the denied flag in status clears on the read that returns it, and that a trim write outside test mode leaves the factory value. The chip-select policy is tested for the values 00, 01 and 11 by changing the configuration and rebooting, which would catch swapped policy encodings.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int BANK_W = 2;

    typedef enum logic [0:0] {
        ST_BOOT  = 1'b0,
        ST_READY = 1'b1
    } ctl_state_e;

    localparam logic [BANK_W-1:0] BANK_OTP  = 2'd0;
    localparam logic [BANK_W-1:0] BANK_CTL  = 2'd1;
    localparam logic [BANK_W-1:0] BANK_AUTH = 2'd2;

    // bank 0
    localparam logic [ADDR_W-1:0] A_CFG    = 4'h0;
    localparam logic [ADDR_W-1:0] A_TRIM   = 4'h1;
    localparam int                SEC_BASE = 2;
    // bank 1
    localparam logic [ADDR_W-1:0] A_MCTL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'h1;
    // bank 2
    localparam logic [ADDR_W-1:0] A_SEL     = 4'h0;
    localparam int                CHAL_BASE = 1;

    // master control: writable bits (srst bit 0 is clear-on-write)
    localparam logic [DATA_W-1:0] MCTL_RW_MASK = 8'hC2;

    // chip-select match policy
    function automatic logic cs_policy(input logic [1:0] pol, input logic cs);
        case (pol)
            2'b00:   return !cs;
            2'b11:   return cs;
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/secreg_otp.sv
module secreg_otp
    import secreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG_INIT    = 8'h5C,
    parameter logic [DATA_W-1:0] TRIM_INIT   = 8'h5A,
    parameter int                SEC_A_WORDS = 8,
    parameter int                SEC_B_WORDS = 4
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              test_mode,
    input  logic              acc_fire,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              wr_enable,
    input  logic [1:0]        lock_eff,
    output logic [DATA_W-1:0] rd_data,
    output logic              deny,
    output logic [DATA_W-1:0] cfg_word
);

    localparam int N_SEC   = SEC_A_WORDS + SEC_B_WORDS;
    localparam int SEC_END = SEC_BASE + N_SEC;
    localparam logic [ADDR_W-1:0] SEC_LO  = ADDR_W'(SEC_BASE);
    localparam logic [ADDR_W-1:0] SEC_HI  = ADDR_W'(SEC_END);
    localparam logic [ADDR_W-1:0] A_SPLIT = ADDR_W'(SEC_A_WORDS);

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] trim_q;
    logic [DATA_W-1:0] sec_q [N_SEC];

    logic              is_sec;
    logic              in_set_a;
    logic              sec_locked;
    logic              frozen;
    logic              base_ok;
    logic              write_blocked;
    logic [ADDR_W-1:0] sec_off;

    always_comb begin
        sec_off       = acc_addr - SEC_LO;
        is_sec        = (acc_addr >= SEC_LO) && (acc_addr < SEC_HI);
        in_set_a      = sec_off < A_SPLIT;
        sec_locked    = is_sec && (in_set_a ? lock_eff[1] : lock_eff[0]);
        frozen        = |lock_eff;
        base_ok       = acc_fire && acc_write && wr_enable && !frozen;
        write_blocked = !wr_enable || frozen || ((acc_addr == A_TRIM) && !test_mode);
        deny          = acc_fire && (acc_addr < SEC_HI)
                        && (sec_locked || (acc_write && write_blocked));
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cfg_q  <= CFG_INIT;
            trim_q <= TRIM_INIT;
        end else begin
            if (base_ok && acc_addr == A_CFG)
                cfg_q <= acc_wdata;
            if (base_ok && test_mode && acc_addr == A_TRIM)
                trim_q <= acc_wdata;
        end
    end

    for (genvar g = 0; g < N_SEC; g++) begin : g_sec
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n)
                sec_q[g] <= '0;
            else if (base_ok && is_sec && sec_off == ADDR_W'(g))
                sec_q[g] <= acc_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc_addr == A_CFG)
            rd_data = cfg_q;
        else if (acc_addr == A_TRIM)
            rd_data = trim_q;
        else if (is_sec && !sec_locked)
            rd_data = sec_q[sec_off];
    end

    assign cfg_word = cfg_q;

    assert_trim_gate_R6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (acc_fire && acc_write && acc_addr == A_TRIM && !test_mode) |=> $stable(trim_q));

    assert_frozen_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        frozen |=> $stable(cfg_q) && $stable(trim_q));

    assert_wr_enable_gate_R5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (acc_fire && acc_write && !wr_enable) |=> $stable(cfg_q) && $stable(trim_q));

endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
    import secreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_fire,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] cfg_word,
    input  logic              otp_deny,
    output logic              ready,
    output logic              boot,
    output logic              wr_enable,
    output logic [1:0]        lock_eff,
    output logic [1:0]        policy_eff,
    output logic [1:0]        rate_eff,
    output logic [DATA_W-1:0] rd_data
);

    ctl_state_e        state_q, state_nx;
    logic [DATA_W-1:0] mctl_q;
    logic [1:0]        lock_q;
    logic [1:0]        policy_q;
    logic [1:0]        rate_q;
    logic              denied_q;
    logic              srst_hit;
    logic              stat_rd;

    assign srst_hit = acc_fire && acc_write && acc_addr == A_MCTL && acc_wdata[0];
    assign stat_rd  = acc_fire && !acc_write && acc_addr == A_STAT;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_BOOT:  state_nx = ST_READY;
            ST_READY: state_nx = srst_hit ? ST_BOOT : ST_READY;
        endcase
    end

    // state outputs
    always_comb begin
        ready = 1'b0;
        boot  = 1'b0;
        unique case (state_q)
            ST_BOOT:  boot  = 1'b1;
            ST_READY: ready = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mctl_q   <= '0;
            lock_q   <= '0;
            policy_q <= '0;
            rate_q   <= '0;
            denied_q <= 1'b0;
        end else if (boot) begin
            mctl_q   <= {1'b0, cfg_word[3], 4'b0000, cfg_word[2], 1'b0};
            lock_q   <= cfg_word[1:0];
            policy_q <= cfg_word[7:6];
            rate_q   <= cfg_word[5:4];
            denied_q <= 1'b0;
        end else begin
            if (acc_fire && acc_write && acc_addr == A_MCTL)
                mctl_q <= acc_wdata & MCTL_RW_MASK;
            if (otp_deny)
                denied_q <= 1'b1;
            else if (stat_rd)
                denied_q <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        if (acc_addr == A_MCTL)
            rd_data = mctl_q;
        else if (acc_addr == A_STAT)
            rd_data = {policy_q, rate_q, denied_q, |lock_q, lock_q};
    end

    assign wr_enable  = mctl_q[7];
    assign lock_eff   = lock_q;
    assign policy_eff = policy_q;
    assign rate_eff   = rate_q;

    assert_boot_one_cycle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BOOT) |=> (state_q == ST_READY));

    assert_srst_reboot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_hit |=> !ready);

    assert_lock_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !srst_hit) |=> $stable(lock_q) && $stable(policy_q));

    assert_denied_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !otp_deny && ready) |=> !denied_q);

endmodule

// File: rtl/secreg_auth.sv
module secreg_auth
    import secreg_pkg::*;
#(
    parameter int CHAL_BYTES = 4,
    parameter int SEL_W      = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     acc_fire,
    input  logic                     acc_write,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [DATA_W-1:0]        acc_wdata,
    output logic [DATA_W-1:0]        rd_data,
    output logic [CHAL_BYTES*DATA_W-1:0] chal_word
);

    logic [SEL_W-1:0]  sel_q;
    logic [DATA_W-1:0] chal_q [CHAL_BYTES];
    logic              sel_we;

    assign sel_we = acc_fire && acc_write && acc_addr == A_SEL;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      sel_q <= '0;
        else if (clear)  sel_q <= '0;
        else if (sel_we) sel_q <= acc_wdata[SEL_W-1:0];
    end

    for (genvar g = 0; g < CHAL_BYTES; g++) begin : g_chal
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                chal_q[g] <= '0;
            else if (clear)
                chal_q[g] <= '0;
            else if (acc_fire && acc_write && acc_addr == ADDR_W'(CHAL_BASE + g))
                chal_q[g] <= acc_wdata;
        end
        assign chal_word[g*DATA_W +: DATA_W] = chal_q[g];
    end

    // challenge bytes are write-only: only the selector is visible
    always_comb begin
        rd_data = '0;
        if (acc_addr == A_SEL)
            rd_data = DATA_W'(sel_q);
    end

    assert_sel_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_we && !clear) |=> $stable(sel_q));

endmodule

// File: rtl/secreg_bank.sv
module secreg_bank
    import secreg_pkg::*;
#(
    parameter logic [DATA_W-1:0] CFG_INIT    = 8'h5C,
    parameter logic [DATA_W-1:0] TRIM_INIT   = 8'h5A,
    parameter int                SEC_A_WORDS = 8,
    parameter int                SEC_B_WORDS = 4,
    parameter int                CHAL_BYTES  = 4
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         rst_n,
    input  logic                         test_mode,
    input  logic                         acc_valid,
    input  logic                         acc_write,
    input  logic [BANK_W-1:0]            acc_bank,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [DATA_W-1:0]            acc_wdata,
    output logic                         ready,
    output logic                         rd_valid,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         frame_cs,
    output logic                         cs_hit,
    output logic [1:0]                   rate_sel,
    output logic [CHAL_BYTES*DATA_W-1:0] chal_word
);

    localparam logic [ADDR_W-1:0] A_LAST = ADDR_W'(SEC_BASE + SEC_A_WORDS - 1);

    logic              fire;
    logic              fire_otp, fire_ctl, fire_auth;
    logic              boot;
    logic              wr_enable;
    logic              otp_deny;
    logic [1:0]        lock_eff;
    logic [1:0]        policy_eff;
    logic [DATA_W-1:0] cfg_word;
    logic [DATA_W-1:0] otp_rd, ctl_rd, auth_rd, rd_mux;

    assign fire      = acc_valid && ready;
    assign fire_otp  = fire && acc_bank == BANK_OTP;
    assign fire_ctl  = fire && acc_bank == BANK_CTL;
    assign fire_auth = fire && acc_bank == BANK_AUTH;

    secreg_otp #(
        .CFG_INIT    (CFG_INIT),
        .TRIM_INIT   (TRIM_INIT),
        .SEC_A_WORDS (SEC_A_WORDS),
        .SEC_B_WORDS (SEC_B_WORDS)
    ) otp_i (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .test_mode (test_mode),
        .acc_fire  (fire_otp),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .wr_enable (wr_enable),
        .lock_eff  (lock_eff),
        .rd_data   (otp_rd),
        .deny      (otp_deny),
        .cfg_word  (cfg_word)
    );

    secreg_ctrl ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_fire   (fire_ctl),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .cfg_word   (cfg_word),
        .otp_deny   (otp_deny),
        .ready      (ready),
        .boot       (boot),
        .wr_enable  (wr_enable),
        .lock_eff   (lock_eff),
        .policy_eff (policy_eff),
        .rate_eff   (rate_sel),
        .rd_data    (ctl_rd)
    );

    secreg_auth #(
        .CHAL_BYTES (CHAL_BYTES),
        .SEL_W      (2)
    ) auth_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (boot),
        .acc_fire  (fire_auth),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .rd_data   (auth_rd),
        .chal_word (chal_word)
    );

    always_comb begin
        case (acc_bank)
            BANK_OTP:  rd_mux = otp_rd;
            BANK_CTL:  rd_mux = ctl_rd;
            BANK_AUTH: rd_mux = auth_rd;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= fire && !acc_write;
            rd_data  <= (fire && !acc_write) ? rd_mux : '0;
        end
    end

    assign cs_hit = cs_policy(policy_eff, frame_cs);

    assert_rd_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && ready && !acc_write));

    assert_locked_a_zero_R4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (fire_otp && !acc_write && lock_eff[1]
         && acc_addr >= ADDR_W'(SEC_BASE) && acc_addr <= A_LAST) |=> rd_data == '0);

    assert_ready_in_reset_R1: assert property (@(posedge clk)
        !rst_n |-> !ready && !rd_valid);

endmodule

// File: tb/secreg_bank_tb_top.sv
`timescale 1ns/100ps
module secreg_bank_tb_top;

    logic        clk = 1'b0;
    logic        por_n, rst_n, test_mode;
    logic        acc_valid, acc_write;
    logic [1:0]  acc_bank;
    logic [3:0]  acc_addr;
    logic [7:0]  acc_wdata;
    logic        ready, rd_valid;
    logic [7:0]  rd_data;
    logic        frame_cs, cs_hit;
    logic [1:0]  rate_sel;
    logic [31:0] chal_word;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    secreg_bank dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .test_mode(test_mode),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_bank(acc_bank),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ready(ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .frame_cs(frame_cs),
        .cs_hit(cs_hit), .rate_sel(rate_sel), .chal_word(chal_word)
    );

    // {req[4], chk, tm, wr, bank[2], addr[4], wdata[8], exp[8]}
    localparam int NV = 30;
    localparam logic [28:0] VEC [NV] = '{
        {4'd2,  1'b1,1'b0,1'b0,2'd1,4'h0,8'h00,8'h42}, // R2 boot defaults
        {4'd8,  1'b1,1'b0,1'b0,2'd1,4'h1,8'h00,8'h50}, // R8 status layout
        {4'd5,  1'b0,1'b0,1'b1,2'd0,4'h2,8'hA5,8'h00}, // R5 no write enable
        {4'd5,  1'b1,1'b0,1'b0,2'd0,4'h2,8'h00,8'h00},
        {4'd8,  1'b1,1'b0,1'b0,2'd1,4'h1,8'h00,8'h58}, // R8 denied set
        {4'd8,  1'b1,1'b0,1'b0,2'd1,4'h1,8'h00,8'h50}, // R8 cleared by read
        {4'd2,  1'b0,1'b0,1'b1,2'd1,4'h0,8'hFE,8'h00}, // R2 write mctl
        {4'd2,  1'b1,1'b0,1'b0,2'd1,4'h0,8'h00,8'hC2},
        {4'd4,  1'b0,1'b0,1'b1,2'd0,4'h2,8'hA5,8'h00}, // R4 set A first byte
        {4'd4,  1'b1,1'b0,1'b0,2'd0,4'h2,8'h00,8'hA5},
        {4'd4,  1'b0,1'b0,1'b1,2'd0,4'hD,8'h3C,8'h00}, // R4 set B last byte
        {4'd4,  1'b1,1'b0,1'b0,2'd0,4'hD,8'h00,8'h3C},
        {4'd6,  1'b0,1'b0,1'b1,2'd0,4'h1,8'h77,8'h00}, // R6 trim outside test
        {4'd6,  1'b1,1'b0,1'b0,2'd0,4'h1,8'h00,8'h5A},
        {4'd8,  1'b1,1'b0,1'b0,2'd1,4'h1,8'h00,8'h58},
        {4'd6,  1'b0,1'b1,1'b1,2'd0,4'h1,8'h77,8'h00}, // R6 trim in test
        {4'd6,  1'b1,1'b0,1'b0,2'd0,4'h1,8'h00,8'h77},
        {4'd10, 1'b0,1'b0,1'b1,2'd2,4'h1,8'h11,8'h00}, // R10 challenge
        {4'd10, 1'b0,1'b0,1'b1,2'd2,4'h2,8'h22,8'h00},
        {4'd10, 1'b0,1'b0,1'b1,2'd2,4'h3,8'h33,8'h00},
        {4'd10, 1'b0,1'b0,1'b1,2'd2,4'h4,8'h44,8'h00},
        {4'd10, 1'b1,1'b0,1'b0,2'd2,4'h1,8'h00,8'h00},
        {4'd10, 1'b0,1'b0,1'b1,2'd2,4'h0,8'hFF,8'h00}, // R10 selector
        {4'd10, 1'b1,1'b0,1'b0,2'd2,4'h0,8'h00,8'h03},
        {4'd11, 1'b1,1'b0,1'b0,2'd0,4'hE,8'h00,8'h00}, // R11 unimplemented
        {4'd11, 1'b0,1'b0,1'b1,2'd1,4'h1,8'hFF,8'h00}, // R11 status read-only
        {4'd11, 1'b1,1'b0,1'b0,2'd1,4'h1,8'h00,8'h50},
        {4'd11, 1'b1,1'b0,1'b0,2'd3,4'h0,8'h00,8'h00},
        {4'd11, 1'b0,1'b0,1'b1,2'd1,4'h5,8'hFF,8'h00},
        {4'd11, 1'b1,1'b0,1'b0,2'd1,4'h5,8'h00,8'h00}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // call at a negedge; returns at the negedge after the accepting edge
    task automatic acc(input logic tm, input logic wr, input logic [1:0] b,
                       input logic [3:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output logic vld);
        while (!ready) @(negedge clk);
        test_mode = tm; acc_valid = 1'b1; acc_write = wr;
        acc_bank = b; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        rd = rd_data; vld = rd_valid;
        acc_valid = 1'b0; acc_write = 1'b0; test_mode = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] b, input logic [3:0] a, input logic [7:0] exp, input string req);
        logic [7:0] r;
        logic v;
        acc(1'b0, 1'b0, b, a, 8'h00, r, v);
        check(v && r == exp, req, {23'd0, v, r}, {23'd0, 1'b1, exp});
    endtask

    task automatic wr_do(input logic tm, input logic [1:0] b, input logic [3:0] a, input logic [7:0] d);
        logic [7:0] r;
        logic v;
        acc(tm, 1'b1, b, a, d, r, v);
    endtask

    task automatic cs_chk(input logic cs, input logic exp, input string req);
        frame_cs = cs;
        #1;
        check(cs_hit == exp, req, {31'd0, cs_hit}, {31'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        por_n = 1'b0; rst_n = 1'b0; test_mode = 1'b0; frame_cs = 1'b0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_bank = '0; acc_addr = '0; acc_wdata = '0;
        repeat (3) @(negedge clk);
        check(!ready && !rd_valid, "R1", {30'd0, ready, rd_valid}, 32'd0);
        por_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        check(!ready, "R1", {31'd0, ready}, 32'd0);
        @(negedge clk);
        check(ready, "R1", {31'd0, ready}, 32'd1);
        check(rate_sel == 2'b01, "R12", {30'd0, rate_sel}, 32'd1);
        cs_chk(1'b0, 1'b1, "R3");
        cs_chk(1'b1, 1'b1, "R3");
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            logic [7:0]  r;
            logic        vl;
            v = VEC[i];
            acc(v[23], v[22], v[21:20], v[19:16], v[15:8], r, vl);
            if (v[24]) begin
                check(vl && r == v[7:0], $sformatf("R%0d vec %0d", v[28:25], i),
                      {23'd0, vl, r}, {23'd0, 1'b1, v[7:0]});
            end else begin
                check(!vl, "R7", {31'd0, vl}, 32'd0);
            end
        end
        check(chal_word == 32'h44332211, "R10", chal_word, 32'h44332211);

        // new config: policy 00, rate 11, defaults 0, no locks
        wr_do(1'b0, 2'd0, 4'h0, 8'h30);
        rd_chk(2'd0, 4'h0, 8'h30, "R12");
        check(rate_sel == 2'b01, "R12", {30'd0, rate_sel}, 32'd1);
        wr_do(1'b0, 2'd1, 4'h0, 8'h01);
        check(!ready, "R9", {31'd0, ready}, 32'd0);
        @(negedge clk);
        check(ready, "R1", {31'd0, ready}, 32'd1);
        rd_chk(2'd1, 4'h0, 8'h00, "R9 R2");
        check(rate_sel == 2'b11, "R12", {30'd0, rate_sel}, 32'd3);
        check(chal_word == 32'd0, "R10", chal_word, 32'd0);
        cs_chk(1'b0, 1'b1, "R3");
        cs_chk(1'b1, 1'b0, "R3");
        rd_chk(2'd1, 4'h1, 8'h30, "R8");

        // set policy 11 and lock set A; not yet in effect
        wr_do(1'b0, 2'd1, 4'h0, 8'h80);
        wr_do(1'b0, 2'd0, 4'h0, 8'hDE);
        rd_chk(2'd0, 4'h0, 8'hDE, "R5");
        rd_chk(2'd0, 4'h2, 8'hA5, "R5");
        cs_chk(1'b0, 1'b1, "R5");
        wr_do(1'b0, 2'd1, 4'h0, 8'h01);
        while (!ready) @(negedge clk);
        cs_chk(1'b0, 1'b0, "R3");
        cs_chk(1'b1, 1'b1, "R3");
        rd_chk(2'd1, 4'h0, 8'h42, "R2");
        rd_chk(2'd0, 4'h2, 8'h00, "R4");
        rd_chk(2'd0, 4'h9, 8'h00, "R4");
        rd_chk(2'd0, 4'hD, 8'h3C, "R4");
        wr_do(1'b0, 2'd1, 4'h0, 8'h80);
        wr_do(1'b0, 2'd0, 4'hD, 8'h99);
        rd_chk(2'd0, 4'hD, 8'h3C, "R5");
        wr_do(1'b0, 2'd0, 4'h0, 8'h00);
        rd_chk(2'd0, 4'h0, 8'hDE, "R5");
        wr_do(1'b1, 2'd0, 4'h1, 8'h11);
        rd_chk(2'd0, 4'h1, 8'h77, "R5");
        wr_do(1'b0, 2'd0, 4'h2, 8'hFF);
        rd_chk(2'd1, 4'h1, 8'hDE, "R8");
        rd_chk(2'd1, 4'h1, 8'hD6, "R8");

        // device reset keeps OTP contents
        rst_n = 1'b0;
        @(negedge clk);
        check(!ready && !rd_valid, "R1", {30'd0, ready, rd_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(2'd0, 4'h0, 8'hDE, "R12");
        rd_chk(2'd0, 4'hD, 8'h3C, "R12");
        rd_chk(2'd0, 4'h2, 8'h00, "R4");

        // power-on restores factory values
        por_n = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        rd_chk(2'd0, 4'h0, 8'h5C, "R12");
        rd_chk(2'd0, 4'h2, 8'h00, "R12");
        rd_chk(2'd0, 4'h1, 8'h5A, "R12");

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule